// File: doc/BRIEF.md
# RISC Instruction Field Decoder

This block splits a 32-bit instruction word of a classic three-format RISC encoding into the pieces a pipeline needs next. It reports the format class (register, immediate, jump), an operation code, the two source register indices, the write-back register index with its write enable, the immediate extended to the datapath width, and the 26-bit jump target. Words outside the supported subset raise an illegal flag.

The supported operations are add, sub, and, or, slt, mult, div and jr in the register format, addi, andi, ori, slti, beq, bne, bgtz, lw, sw, lb and sb in the immediate format, and j and jal in the jump format. The decode is combinational. One output register stage captures the result when `valid_i` is high, so results appear one clock after the word is presented.

Top module: `rid_decoder`

## Requirements
- R1: A word presented with `valid_i` high at a rising edge appears decoded on the outputs after that edge, with `valid_o` high. `valid_o` is low after an edge where `valid_i` was low. After reset `valid_o`, `wr_en_o` and `illegal_o` are 0.
- R2: After an edge where `valid_i` is low, every decoded output keeps its previous value.
- R3: `rs_o` is bits [25:21] and `rt_o` is bits [20:16] of the captured word, for every word, legal or not.
- R4: Opcode 0 with shift field [10:6] equal to 0 selects a register-format operation by the function field [5:0]: 32 add (op 0), 34 sub (op 1), 36 and (op 2), 37 or (op 3), 42 slt (op 4), 24 mult (op 5), 26 div (op 6), 8 jr (op 7). `fmt_o` is 0.
- R5: Immediate-format opcodes give `fmt_o` = 1 and op: 8 addi (8), 12 andi (9), 13 ori (10), 10 slti (11), 4 beq (12), 5 bne (13), 7 bgtz (14), 35 lw (15), 43 sw (16), 32 lb (17), 40 sb (18).
- R6: Opcode 2 (j, op 19) and opcode 3 (jal, op 20) give `fmt_o` = 2 and `target_o` = bits [25:0]. All other words give `target_o` = 0.
- R7: add, sub, and, or and slt write register bits [15:11] (`dest_o`), with `wr_en_o` = 1.
- R8: addi, andi, ori, slti, lw and lb write register bits [20:16], with `wr_en_o` = 1.
- R9: jal writes register 31 (parameter `LINK_REG`), with `wr_en_o` = 1.
- R10: mult, div, jr, beq, bne, bgtz, sw, sb and j give `wr_en_o` = 0 and `dest_o` = 0.
- R11: addi, slti, beq, bne, bgtz, lw, sw, lb and sb sign-extend bits [15:0] to `DATA_W` bits on `imm_o`. Register- and jump-format words give `imm_o` = 0.
- R12: andi and ori zero-extend bits [15:0] on `imm_o`.
- R13: An unknown opcode, an unknown function code under opcode 0, or a nonzero shift field under opcode 0 gives `illegal_o` = 1, op 31, `fmt_o` = 3, `wr_en_o` = 0, `dest_o` = 0, `imm_o` = 0 and `target_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction word valid |
| instr_i | input | 32 | Instruction word |
| valid_o | output | 1 | Decoded result valid |
| fmt_o | output | 2 | Format: 0 register, 1 immediate, 2 jump, 3 illegal |
| op_o | output | 5 | Operation code (31 when illegal) |
| rs_o | output | 5 | First source register index |
| rt_o | output | 5 | Second source register index |
| dest_o | output | 5 | Write-back register index |
| wr_en_o | output | 1 | Register write enable |
| imm_o | output | DATA_W | Extended immediate |
| target_o | output | 26 | Jump target field |
| illegal_o | output | 1 | Unsupported encoding |

## Verification
Hand-assembled words with known encodings fix each field position, and pairs such as andi and addi with bit 15 set separate zero from sign extension. The link register case, the store and branch no-write cases and the illegal words (unknown opcode, unknown function code, nonzero shift field under opcode 0) are driven directly. Random words drawn mostly from the legal opcode and function lists, mixed with fully random words and idle cycles, cover the remaining combinations and check that outputs hold while `valid_i` is low.

// File: rtl/rid_pkg.sv
package rid_pkg;
  localparam int unsigned INSTR_W = 32;
  localparam int unsigned REG_W   = 5;
  localparam int unsigned IMM_W   = 16;
  localparam int unsigned TGT_W   = 26;
  localparam int unsigned OPC_W   = 6;

  typedef enum logic [1:0] {
    FMT_R   = 2'd0,
    FMT_I   = 2'd1,
    FMT_J   = 2'd2,
    FMT_BAD = 2'd3
  } fmt_e;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,  OP_SUB  = 5'd1,  OP_AND  = 5'd2,  OP_OR   = 5'd3,
    OP_SLT  = 5'd4,  OP_MULT = 5'd5,  OP_DIV  = 5'd6,  OP_JR   = 5'd7,
    OP_ADDI = 5'd8,  OP_ANDI = 5'd9,  OP_ORI  = 5'd10, OP_SLTI = 5'd11,
    OP_BEQ  = 5'd12, OP_BNE  = 5'd13, OP_BGTZ = 5'd14, OP_LW   = 5'd15,
    OP_SW   = 5'd16, OP_LB   = 5'd17, OP_SB   = 5'd18, OP_J    = 5'd19,
    OP_JAL  = 5'd20, OP_BAD  = 5'd31
  } op_e;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_RD   = 2'd1,
    DST_RT   = 2'd2,
    DST_LINK = 2'd3
  } dst_e;

  typedef enum logic [1:0] {
    IMM_NONE = 2'd0,
    IMM_SEXT = 2'd1,
    IMM_ZEXT = 2'd2
  } imm_e;

  typedef struct packed {
    fmt_e fmt;
    op_e  op;
    dst_e dst;
    imm_e imm;
  } ctrl_t;

  // primary opcodes
  localparam logic [5:0] OPC_SPECIAL = 6'd0;
  localparam logic [5:0] OPC_J    = 6'd2;
  localparam logic [5:0] OPC_JAL  = 6'd3;
  localparam logic [5:0] OPC_BEQ  = 6'd4;
  localparam logic [5:0] OPC_BNE  = 6'd5;
  localparam logic [5:0] OPC_BGTZ = 6'd7;
  localparam logic [5:0] OPC_ADDI = 6'd8;
  localparam logic [5:0] OPC_SLTI = 6'd10;
  localparam logic [5:0] OPC_ANDI = 6'd12;
  localparam logic [5:0] OPC_ORI  = 6'd13;
  localparam logic [5:0] OPC_LB   = 6'd32;
  localparam logic [5:0] OPC_LW   = 6'd35;
  localparam logic [5:0] OPC_SB   = 6'd40;
  localparam logic [5:0] OPC_SW   = 6'd43;

  // function codes under OPC_SPECIAL
  localparam logic [5:0] FN_JR   = 6'd8;
  localparam logic [5:0] FN_MULT = 6'd24;
  localparam logic [5:0] FN_DIV  = 6'd26;
  localparam logic [5:0] FN_ADD  = 6'd32;
  localparam logic [5:0] FN_SUB  = 6'd34;
  localparam logic [5:0] FN_AND  = 6'd36;
  localparam logic [5:0] FN_OR   = 6'd37;
  localparam logic [5:0] FN_SLT  = 6'd42;
endpackage

// File: rtl/rid_class.sv
module rid_class
  import rid_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  input  logic [OPC_W-1:0] funct_i,
  input  logic [REG_W-1:0] shamt_i,
  output ctrl_t            ctrl_o
);
  ctrl_t spec;

  // register-format table; shift field must be zero
  always_comb begin
    spec = '{fmt: FMT_BAD, op: OP_BAD, dst: DST_NONE, imm: IMM_NONE};
    if (shamt_i == '0) begin
      case (funct_i)
        FN_ADD:  spec = '{fmt: FMT_R, op: OP_ADD,  dst: DST_RD,   imm: IMM_NONE};
        FN_SUB:  spec = '{fmt: FMT_R, op: OP_SUB,  dst: DST_RD,   imm: IMM_NONE};
        FN_AND:  spec = '{fmt: FMT_R, op: OP_AND,  dst: DST_RD,   imm: IMM_NONE};
        FN_OR:   spec = '{fmt: FMT_R, op: OP_OR,   dst: DST_RD,   imm: IMM_NONE};
        FN_SLT:  spec = '{fmt: FMT_R, op: OP_SLT,  dst: DST_RD,   imm: IMM_NONE};
        FN_MULT: spec = '{fmt: FMT_R, op: OP_MULT, dst: DST_NONE, imm: IMM_NONE};
        FN_DIV:  spec = '{fmt: FMT_R, op: OP_DIV,  dst: DST_NONE, imm: IMM_NONE};
        FN_JR:   spec = '{fmt: FMT_R, op: OP_JR,   dst: DST_NONE, imm: IMM_NONE};
        default: ;
      endcase
    end
  end

  always_comb begin
    ctrl_o = '{fmt: FMT_BAD, op: OP_BAD, dst: DST_NONE, imm: IMM_NONE};
    case (opcode_i)
      OPC_SPECIAL: ctrl_o = spec;
      OPC_ADDI: ctrl_o = '{fmt: FMT_I, op: OP_ADDI, dst: DST_RT,   imm: IMM_SEXT};
      OPC_SLTI: ctrl_o = '{fmt: FMT_I, op: OP_SLTI, dst: DST_RT,   imm: IMM_SEXT};
      OPC_ANDI: ctrl_o = '{fmt: FMT_I, op: OP_ANDI, dst: DST_RT,   imm: IMM_ZEXT};
      OPC_ORI:  ctrl_o = '{fmt: FMT_I, op: OP_ORI,  dst: DST_RT,   imm: IMM_ZEXT};
      OPC_LW:   ctrl_o = '{fmt: FMT_I, op: OP_LW,   dst: DST_RT,   imm: IMM_SEXT};
      OPC_LB:   ctrl_o = '{fmt: FMT_I, op: OP_LB,   dst: DST_RT,   imm: IMM_SEXT};
      OPC_SW:   ctrl_o = '{fmt: FMT_I, op: OP_SW,   dst: DST_NONE, imm: IMM_SEXT};
      OPC_SB:   ctrl_o = '{fmt: FMT_I, op: OP_SB,   dst: DST_NONE, imm: IMM_SEXT};
      OPC_BEQ:  ctrl_o = '{fmt: FMT_I, op: OP_BEQ,  dst: DST_NONE, imm: IMM_SEXT};
      OPC_BNE:  ctrl_o = '{fmt: FMT_I, op: OP_BNE,  dst: DST_NONE, imm: IMM_SEXT};
      OPC_BGTZ: ctrl_o = '{fmt: FMT_I, op: OP_BGTZ, dst: DST_NONE, imm: IMM_SEXT};
      OPC_J:    ctrl_o = '{fmt: FMT_J, op: OP_J,    dst: DST_NONE, imm: IMM_NONE};
      OPC_JAL:  ctrl_o = '{fmt: FMT_J, op: OP_JAL,  dst: DST_LINK, imm: IMM_NONE};
      default: ;
    endcase
  end
endmodule

// File: rtl/rid_dest.sv
module rid_dest
  import rid_pkg::*;
#(
  parameter int unsigned LINK_REG = 31
) (
  input  dst_e             sel_i,
  input  logic [REG_W-1:0] rt_i,
  input  logic [REG_W-1:0] rd_i,
  output logic [REG_W-1:0] dest_o,
  output logic             wr_en_o
);
  localparam logic [REG_W-1:0] LinkIdx = REG_W'(LINK_REG);

  always_comb begin
    dest_o  = '0;
    wr_en_o = 1'b1;
    case (sel_i)
      DST_RD:   dest_o = rd_i;
      DST_RT:   dest_o = rt_i;
      DST_LINK: dest_o = LinkIdx;
      default:  wr_en_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/rid_imm.sv
module rid_imm
  import rid_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  imm_e              mode_i,
  input  logic [IMM_W-1:0]  raw_i,
  output logic [DATA_W-1:0] imm_o
);
  localparam int unsigned ExtW = DATA_W - IMM_W;

  generate
    if (ExtW == 0) begin : g_no_ext
      always_comb imm_o = (mode_i == IMM_NONE) ? '0 : raw_i;
    end else begin : g_ext
      logic fill;
      always_comb begin
        fill  = (mode_i == IMM_SEXT) & raw_i[IMM_W-1];
        imm_o = (mode_i == IMM_NONE) ? '0 : {{ExtW{fill}}, raw_i};
      end
    end
  endgenerate
endmodule

// File: rtl/rid_decoder.sv
module rid_decoder
  import rid_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned LINK_REG = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [31:0]       instr_i,
  output logic              valid_o,
  output logic [1:0]        fmt_o,
  output logic [4:0]        op_o,
  output logic [4:0]        rs_o,
  output logic [4:0]        rt_o,
  output logic [4:0]        dest_o,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] imm_o,
  output logic [25:0]       target_o,
  output logic              illegal_o
);
  ctrl_t             ctrl;
  logic [REG_W-1:0]  dest_d;
  logic              wr_en_d;
  logic [DATA_W-1:0] imm_d;
  logic [TGT_W-1:0]  tgt_d;

  rid_class u_class (
    .opcode_i (instr_i[31:26]),
    .funct_i  (instr_i[5:0]),
    .shamt_i  (instr_i[10:6]),
    .ctrl_o   (ctrl)
  );

  rid_dest #(.LINK_REG(LINK_REG)) u_dest (
    .sel_i   (ctrl.dst),
    .rt_i    (instr_i[20:16]),
    .rd_i    (instr_i[15:11]),
    .dest_o  (dest_d),
    .wr_en_o (wr_en_d)
  );

  rid_imm #(.DATA_W(DATA_W)) u_imm (
    .mode_i (ctrl.imm),
    .raw_i  (instr_i[15:0]),
    .imm_o  (imm_d)
  );

  assign tgt_d = (ctrl.fmt == FMT_J) ? instr_i[25:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      fmt_o     <= '0;
      op_o      <= '0;
      rs_o      <= '0;
      rt_o      <= '0;
      dest_o    <= '0;
      wr_en_o   <= 1'b0;
      imm_o     <= '0;
      target_o  <= '0;
      illegal_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        fmt_o     <= ctrl.fmt;
        op_o      <= ctrl.op;
        rs_o      <= instr_i[25:21];
        rt_o      <= instr_i[20:16];
        dest_o    <= dest_d;
        wr_en_o   <= wr_en_d;
        imm_o     <= imm_d;
        target_o  <= tgt_d;
        illegal_o <= (ctrl.fmt == FMT_BAD);
      end
    end
  end
endmodule

// File: rtl/rid_decoder_chk.sv
module rid_decoder_chk #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned LINK_REG = 31
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [31:0]       instr_i,
  input logic              valid_o,
  input logic [1:0]        fmt_o,
  input logic [4:0]        op_o,
  input logic [4:0]        rs_o,
  input logic [4:0]        rt_o,
  input logic [4:0]        dest_o,
  input logic              wr_en_o,
  input logic [DATA_W-1:0] imm_o,
  input logic [25:0]       target_o,
  input logic              illegal_o
);
  p_valid_follow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_valid_drop_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(op_o) && $stable(dest_o) && $stable(imm_o) && $stable(target_o)));
  p_fields_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (rs_o == $past(instr_i[25:21]) && rt_o == $past(instr_i[20:16])));
  p_add_rd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && instr_i[31:26] == 6'd0 && instr_i[10:0] == 11'd32)
    |=> (wr_en_o && dest_o == $past(instr_i[15:11]) && fmt_o == 2'd0));
  p_jump_target_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && instr_i[31:27] == 5'b00001)
    |=> (fmt_o == 2'd2 && target_o == $past(instr_i[25:0])));
  p_link_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && op_o == 5'd20) |-> (wr_en_o && dest_o == 5'(LINK_REG)));
  p_no_write_dest_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_o |-> (dest_o == 5'd0));
  p_sext_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && op_o == 5'd8) |-> (imm_o[DATA_W-1:16] == {(DATA_W-16){imm_o[15]}}));
  p_zext_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && (op_o == 5'd9 || op_o == 5'd10)) |-> (imm_o[DATA_W-1:16] == '0));
  p_illegal_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!wr_en_o && fmt_o == 2'd3 && op_o == 5'd31 && target_o == '0));
endmodule

bind rid_decoder rid_decoder_chk #(.DATA_W(DATA_W), .LINK_REG(LINK_REG)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .instr_i   (instr_i),
  .valid_o   (valid_o),
  .fmt_o     (fmt_o),
  .op_o      (op_o),
  .rs_o      (rs_o),
  .rt_o      (rt_o),
  .dest_o    (dest_o),
  .wr_en_o   (wr_en_o),
  .imm_o     (imm_o),
  .target_o  (target_o),
  .illegal_o (illegal_o)
);

// File: tb/tb_rid_decoder.sv
`timescale 1ns/1ps
module tb_rid_decoder;
  localparam int DATA_W = 32;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              valid_i = 1'b0;
  logic [31:0]       instr_i = '0;
  logic              valid_o;
  logic [1:0]        fmt_o;
  logic [4:0]        op_o, rs_o, rt_o, dest_o;
  logic              wr_en_o;
  logic [DATA_W-1:0] imm_o;
  logic [25:0]       target_o;
  logic              illegal_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  rid_decoder #(.DATA_W(DATA_W), .LINK_REG(31)) dut (.*);

  typedef struct packed {
    logic [1:0]        fmt;
    logic [4:0]        op;
    logic [4:0]        rs, rt, dest;
    logic              wr;
    logic [DATA_W-1:0] imm;
    logic [25:0]       tgt;
    logic              ill;
  } exp_t;

  exp_t last;

  function automatic exp_t model(input logic [31:0] w);
    exp_t e;
    int   op = 31;
    int   kind = 0; // 0 none,1 rd,2 rt,3 link
    int   ext = 0;  // 0 none,1 sign,2 zero
    e = '0;
    if (w[31:26] == 0) begin
      if (w[10:6] == 0)
        case (w[5:0])
          32: begin op = 0; kind = 1; end
          34: begin op = 1; kind = 1; end
          36: begin op = 2; kind = 1; end
          37: begin op = 3; kind = 1; end
          42: begin op = 4; kind = 1; end
          24: op = 5;
          26: op = 6;
          8:  op = 7;
          default: ;
        endcase
    end else
      case (w[31:26])
        8:  begin op = 8;  kind = 2; ext = 1; end
        12: begin op = 9;  kind = 2; ext = 2; end
        13: begin op = 10; kind = 2; ext = 2; end
        10: begin op = 11; kind = 2; ext = 1; end
        4:  begin op = 12; ext = 1; end
        5:  begin op = 13; ext = 1; end
        7:  begin op = 14; ext = 1; end
        35: begin op = 15; kind = 2; ext = 1; end
        43: begin op = 16; ext = 1; end
        32: begin op = 17; kind = 2; ext = 1; end
        40: begin op = 18; ext = 1; end
        2:  op = 19;
        3:  begin op = 20; kind = 3; end
        default: ;
      endcase
    e.op = 5'(op);
    e.rs = w[25:21];
    e.rt = w[20:16];
    e.ill = (op == 31);
    e.fmt = (op == 31) ? 2'd3 : (op <= 7) ? 2'd0 : (op <= 18) ? 2'd1 : 2'd2;
    e.wr = (kind != 0);
    e.dest = (kind == 1) ? w[15:11] : (kind == 2) ? w[20:16] : (kind == 3) ? 5'd31 : 5'd0;
    e.imm = (ext == 1) ? {{(DATA_W-16){w[15]}}, w[15:0]} :
            (ext == 2) ? {{(DATA_W-16){1'b0}}, w[15:0]} : '0;
    e.tgt = (op == 19 || op == 20) ? w[25:0] : '0;
    return e;
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] w);
    @(negedge clk_i);
    valid_i = v;
    instr_i = w;
    @(posedge clk_i);
    #1;
    if (v) last = model(w);
    chk("R1", "valid_o", 64'(valid_o), 64'(v));
    if (!v) begin
      chk("R2", "hold op", 64'(op_o), 64'(last.op));
      chk("R2", "hold dest", 64'(dest_o), 64'(last.dest));
      chk("R2", "hold imm", 64'(imm_o), 64'(last.imm));
    end else begin
      chk("R4 R5 R6", "op", 64'(op_o), 64'(last.op));
      chk("R4 R5 R6", "fmt", 64'(fmt_o), 64'(last.fmt));
      chk("R3", "rs/rt", 64'({rs_o, rt_o}), 64'({last.rs, last.rt}));
      chk("R7 R8 R9 R10", "dest/wr", 64'({dest_o, wr_en_o}), 64'({last.dest, last.wr}));
      chk("R11 R12", "imm", 64'(imm_o), 64'(last.imm));
      chk("R6", "target", 64'(target_o), 64'(last.tgt));
      chk("R13", "illegal", 64'(illegal_o), 64'(last.ill));
    end
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [5:0] opcs [14];
    logic [5:0] fns  [8];
    opcs = '{6'd0, 6'd2, 6'd3, 6'd4, 6'd5, 6'd7, 6'd8, 6'd10, 6'd12, 6'd13, 6'd32, 6'd35, 6'd40, 6'd43};
    fns  = '{6'd8, 6'd24, 6'd26, 6'd32, 6'd34, 6'd36, 6'd37, 6'd42};
    void'($urandom(32'd20240611));
    last = '0;
    #5;
    // reset state R1
    chk("R1", "reset valid_o", 64'(valid_o), 64'd0);
    chk("R1", "reset wr_en_o", 64'(wr_en_o), 64'd0);
    chk("R1", "reset illegal_o", 64'(illegal_o), 64'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    step(1, 32'h014B4820); // add: R7 rd=9
    step(1, 32'h21AC0043); // addi: R8 rt=12, imm 67
    step(1, 32'h11090002); // beq: R10 no write
    step(0, 32'hFFFFFFFF); // idle with garbage: R2
    step(1, 32'h08000029); // j: R6
    step(1, 32'h0C3FFFFF); // jal: R9 link 31
    step(1, 32'h3128_8000); // andi bit15 set: R12
    step(1, 32'h2128_8000); // addi bit15 set: R11
    step(1, 32'h01090018); // mult: R10
    step(1, 32'hAD0A0008); // sw: R10, R11
    step(1, 32'h014B4860); // add with shamt 1: R13
    step(1, 32'h014B4800); // funct 0: R13
    step(1, 32'h04000000); // opcode 1: R13
    step(1, 32'h03E00008); // jr: R10

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] w;
      int r;
      w = $urandom;
      r = $urandom_range(0, 9);
      if (r < 7) begin
        w[31:26] = opcs[$urandom_range(0, 13)];
        if (w[31:26] == 6'd0) begin
          w[5:0] = fns[$urandom_range(0, 7)];
          if (r < 6) w[10:6] = '0;
        end
      end
      step(($urandom_range(0, 7) != 0), w);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule